// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Command Executor

This block sits behind a serial receiver in a two-channel converter and turns each completed 24-bit command word into register actions. Every channel keeps a staging (input) register, an active register that drives the converter code, and a sleep flag. A word carries a 4-bit operation in bits [23:20], a 4-bit channel selector in bits [19:16] and a 16-bit data field in bits [15:0]. The receiver pulses `word_valid` for one clock when the last bit of a word has arrived, and holds `xfer_active` high while a word is being shifted in.

An active-low load strobe, `ldac_n`, arrives asynchronously and is passed through a two-flop synchronizer. While it is low, both channels are kept awake. It copies both staging registers into the active registers, but only once a complete word is on hand. A word that arrives while the strobe is already low is executed first and then loaded, and any sleep request in that word is overridden. A wake-up timer models the power-up settling delay. Its length is short when one channel was asleep before the wake and long when both were asleep.

Top module: `dual_dac_cmd_exec`

## Requirements
- R1: After reset both active codes equal the reset code, both sleep flags are 0 and `busy` is 0. The reset code is 0 when RESET_MID=0 and 2^(CODE_W-1) when RESET_MID=1.
- R2: Operation 4'b0000 loads the selected staging register and leaves the active code unchanged. Operation 4'b0001 copies staging to active and clears the sleep flag, one clock after `word_valid`.
- R3: Operation 4'b0011 loads the staging register and copies the new value to the active register in the same clock.
- R4: Operation 4'b0100 sets the selected sleep flags. It ignores the data field and alters neither register.
- R5: Channel selector 4'b0000 addresses channel A, 4'b0001 channel B and 4'b1111 both.
- R6: Reserved operations, reserved selectors and operation 4'b1111 change no code and no sleep flag.
- R7: When CODE_W is less than 16, the code is taken from data bits [15:16-CODE_W] and the low bits are ignored.
- R8: When the synchronized strobe is low, a complete word is pending and no transfer is active, both staging registers are copied to the active registers. This happens two clocks after `ldac_n` falls, and the copy is visible after the third edge.
- R9: While the synchronized strobe is low, both sleep flags clear. During a transfer this does not change the active codes.
- R10: A word that completes while the strobe is low is executed, then both channels are loaded from the updated staging registers. Any sleep operation in that word is suppressed.
- R11: While `ldac_n` stays high, a written staging value never reaches the active code without an update operation.
- R12: A wake from sleep raises `busy` for WAKE_ONE_CYC clocks when only one channel was asleep, and for WAKE_BOTH_CYC clocks when both were asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | One-clock strobe: a complete command word is present |
| word_data | input | 24 | Operation [23:20], channel [19:16], data [15:0] |
| xfer_active | input | 1 | High while a word is being shifted in |
| ldac_n | input | 1 | Asynchronous active-low load strobe |
| code_a | output | CODE_W | Active code of channel A |
| code_b | output | CODE_W | Active code of channel B |
| pd_a | output | 1 | Channel A asleep |
| pd_b | output | 1 | Channel B asleep |
| busy | output | 1 | Wake-up settling in progress |

## Verification
A table of command words covers every operation against each selector. It also includes reserved operations and selectors placed between real writes, so that a decode slip shows up as a changed code or sleep flag. The load strobe is then driven in three situations, and comparing the codes in each case separates gating by frame state from gating by pending word:
- with a word pending and the bus idle,
- during a transfer,
- held across the completion of a word.

The timer is woken once from a state with both channels asleep and once with one asleep. The bench samples the last busy clock and the first idle clock in each case. A 12-bit instance with midscale reset shows the truncation and the alternate reset code.

// File: rtl/dac_exec_pkg.sv
package dac_exec_pkg;

  typedef enum logic [3:0] {
    OP_LOAD        = 4'b0000,
    OP_COMMIT      = 4'b0001,
    OP_LOAD_COMMIT = 4'b0011,
    OP_SLEEP       = 4'b0100,
    OP_IDLE        = 4'b1111
  } op_e;

  // Channel selector to a two-bit mask, bit 0 = channel A, bit 1 = channel B.
  function automatic logic [1:0] chan_mask(input logic [3:0] field);
    case (field)
      4'b0000: chan_mask = 2'b01;
      4'b0001: chan_mask = 2'b10;
      4'b1111: chan_mask = 2'b11;
      default: chan_mask = 2'b00;
    endcase
  endfunction

  function automatic logic op_loads(input op_e op);
    op_loads = (op == OP_LOAD) || (op == OP_LOAD_COMMIT);
  endfunction

  function automatic logic op_commits(input op_e op);
    op_commits = (op == OP_COMMIT) || (op == OP_LOAD_COMMIT);
  endfunction

  function automatic int max_int(input int x, input int y);
    max_int = (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/ldac_sync.sv
module ldac_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic low_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= async_n;
      s2_q <= s1_q;
    end
  end

  assign low_sync = !s2_q;
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int CODE_W = 16,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              upd_en,
  input  logic              sleep_en,
  input  logic              wake_en,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] act_code,
  output logic              asleep,
  output logic              wake_evt
);
  logic [CODE_W-1:0] stage_q, stage_nxt, act_q;
  logic              pd_q;

  // The write lands first so a load-and-commit forwards the fresh code.
  assign stage_nxt = wr_en ? code_in : stage_q;
  assign wake_evt  = pd_q && (upd_en || wake_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= RESET_CODE;
      act_q   <= RESET_CODE;
      pd_q    <= 1'b0;
    end else begin
      stage_q <= stage_nxt;
      if (upd_en) act_q <= stage_nxt;
      if (upd_en || wake_en) pd_q <= 1'b0;
      else if (sleep_en)     pd_q <= 1'b1;
    end
  end

  assign act_code = act_q;
  assign asleep   = pd_q;
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int ONE_CYC  = 1250,
  parameter int BOTH_CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_any,
  input  logic both_down,
  output logic busy
);
  import dac_exec_pkg::*;
  localparam int MAXC  = max_int(ONE_CYC, BOTH_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt_q, load;

  assign load = both_down ? CNT_W'(BOTH_CYC) : CNT_W'(ONE_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (wake_any)       cnt_q <= (load > cnt_q) ? load : cnt_q;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dual_dac_cmd_exec.sv
module dual_dac_cmd_exec #(
  parameter int CODE_W        = 16,
  parameter int RESET_MID     = 0,
  parameter int WAKE_ONE_CYC  = 1250,
  parameter int WAKE_BOTH_CYC = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [23:0]       word_data,
  input  logic              xfer_active,
  input  logic              ldac_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              pd_a,
  output logic              pd_b,
  output logic              busy
);
  import dac_exec_pkg::*;

  localparam logic [CODE_W-1:0] RESET_CODE =
    (RESET_MID != 0) ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  op_e               op;
  logic [1:0]        sel, wr_hit, upd_hit, sleep_hit, pd_vec, wake_vec;
  logic [CODE_W-1:0] code_in;
  logic [1:0][CODE_W-1:0] act;
  logic              ldac_low, ldac_update, pending_q;

  assign op      = op_e'(word_data[23:20]);
  assign sel     = chan_mask(word_data[19:16]);
  assign code_in = word_data[15 -: CODE_W];

  assign wr_hit    = {2{word_valid && op_loads(op)}}     & sel;
  assign upd_hit   = {2{word_valid && op_commits(op)}}   & sel;
  assign sleep_hit = {2{word_valid && (op == OP_SLEEP)}} & sel;

  ldac_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_n  (ldac_n),
    .low_sync (ldac_low)
  );

  // A word counts as complete from its strobe until a strobe-driven load consumes it.
  always_ff @(posedge clk) begin
    if (!rst_n)           pending_q <= 1'b0;
    else if (ldac_update) pending_q <= 1'b0;
    else if (word_valid)  pending_q <= 1'b1;
  end

  assign ldac_update = ldac_low && (word_valid || (pending_q && !xfer_active));

  for (genvar i = 0; i < 2; i++) begin : g_ch
    dac_channel #(
      .CODE_W     (CODE_W),
      .RESET_CODE (RESET_CODE)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_hit[i]),
      .upd_en   (upd_hit[i] || ldac_update),
      .sleep_en (sleep_hit[i]),
      .wake_en  (ldac_low),
      .code_in  (code_in),
      .act_code (act[i]),
      .asleep   (pd_vec[i]),
      .wake_evt (wake_vec[i])
    );
  end

  wake_timer #(
    .ONE_CYC  (WAKE_ONE_CYC),
    .BOTH_CYC (WAKE_BOTH_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_any  (|wake_vec),
    .both_down (&pd_vec),
    .busy      (busy)
  );

  assign code_a = act[0];
  assign code_b = act[1];
  assign pd_a   = pd_vec[0];
  assign pd_b   = pd_vec[1];
endmodule

// File: rtl/dual_dac_cmd_exec_chk.sv
module dual_dac_cmd_exec_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_valid,
  input logic              xfer_active,
  input logic              ldac_low,
  input logic              ldac_update,
  input logic [1:0]        sel,
  input logic [1:0]        upd_hit,
  input logic [1:0]        sleep_hit,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic              pd_a,
  input logic              pd_b,
  input logic              busy
);
  assert_sleep_src_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_a) |-> ($past(sleep_hit[0]) && !$past(ldac_low)));
  assert_sleep_src_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_b) |-> ($past(sleep_hit[1]) && !$past(ldac_low)));
  assert_out_cause_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_a) |-> $past(upd_hit[0] || ldac_update));
  assert_out_cause_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_b) |-> $past(upd_hit[1] || ldac_update));
  assert_strobe_wakes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ldac_low |=> (!pd_a && !pd_b));
  assert_xfer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_low && xfer_active && !word_valid) |=> ($stable(code_a) && $stable(code_b)));
  assert_reserved_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && (sel == 2'b00) && !ldac_low) |=>
      ($stable(code_a) && $stable(code_b) && $stable(pd_a) && $stable(pd_b)));
  assert_wake_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pd_a) || $fell(pd_b)) |-> busy);
endmodule

bind dual_dac_cmd_exec dual_dac_cmd_exec_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .word_valid  (word_valid),
  .xfer_active (xfer_active),
  .ldac_low    (ldac_low),
  .ldac_update (ldac_update),
  .sel         (sel),
  .upd_hit     (upd_hit),
  .sleep_hit   (sleep_hit),
  .code_a      (code_a),
  .code_b      (code_b),
  .pd_a        (pd_a),
  .pd_b        (pd_b),
  .busy        (busy)
);

// File: tb/dual_dac_cmd_exec_bench.sv
`timescale 1ns/1ps
module dual_dac_cmd_exec_bench;
  localparam int ONE  = 8;
  localparam int BOTH = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_valid = 1'b0;
  logic [23:0] word_data = '0;
  logic xfer_active = 1'b0;
  logic ldac_n = 1'b1;
  logic [15:0] code_a, code_b;
  logic [11:0] n_code_a, n_code_b;
  logic pd_a, pd_b, busy, n_pd_a, n_pd_b, n_busy;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_dac_cmd_exec #(.CODE_W(16), .RESET_MID(0), .WAKE_ONE_CYC(ONE), .WAKE_BOTH_CYC(BOTH))
  u_dual_dac_cmd_exec (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .xfer_active(xfer_active), .ldac_n(ldac_n), .code_a(code_a), .code_b(code_b),
    .pd_a(pd_a), .pd_b(pd_b), .busy(busy));

  dual_dac_cmd_exec #(.CODE_W(12), .RESET_MID(1), .WAKE_ONE_CYC(ONE), .WAKE_BOTH_CYC(BOTH))
  u_dual_dac_cmd_exec_narrow (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .xfer_active(xfer_active), .ldac_n(ldac_n), .code_a(n_code_a), .code_b(n_code_b),
    .pd_a(n_pd_a), .pd_b(n_pd_b), .busy(n_busy));

  // {word[23:0], code_a[15:0], code_b[15:0], pd_a, pd_b}
  localparam logic [57:0] VEC [12] = '{
    {24'h001234, 16'h0000, 16'h0000, 2'b00},
    {24'h100000, 16'h1234, 16'h0000, 2'b00},
    {24'h31ABCD, 16'h1234, 16'hABCD, 2'b00},
    {24'h40FFFF, 16'h1234, 16'hABCD, 2'b10},
    {24'h0F5555, 16'h1234, 16'hABCD, 2'b10},
    {24'h110000, 16'h1234, 16'h5555, 2'b10},
    {24'h700000, 16'h1234, 16'h5555, 2'b10},
    {24'h350000, 16'h1234, 16'h5555, 2'b10},
    {24'hFF0000, 16'h1234, 16'h5555, 2'b10},
    {24'h100000, 16'h5555, 16'h5555, 2'b00},
    {24'h4F0000, 16'h5555, 16'h5555, 2'b11},
    {24'h3F9001, 16'h9001, 16'h9001, 2'b00}
  };

  function automatic string vec_req(input int i);
    case (i)
      0: vec_req = "R2 load A";
      1: vec_req = "R2 commit A";
      2: vec_req = "R3 load-commit B";
      3: vec_req = "R4 sleep A";
      4: vec_req = "R5 load both";
      5: vec_req = "R2 commit B";
      6: vec_req = "R6 reserved op";
      7: vec_req = "R6 reserved chan";
      8: vec_req = "R6 idle op";
      9: vec_req = "R2 wake by commit";
      10: vec_req = "R5 sleep both";
      default: vec_req = "R3 load-commit both";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] w);
    @(negedge clk);
    word_valid = 1'b1;
    word_data  = w;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state, both reset flavours
    chk("R1 code_a", 32'(code_a), 32'h0);
    chk("R1 code_b", 32'(code_b), 32'h0);
    chk("R1 pd", {30'b0, pd_a, pd_b}, 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 midscale a", 32'(n_code_a), 32'h800);
    chk("R1 midscale b", 32'(n_code_b), 32'h800);

    for (int i = 0; i < 12; i++) begin
      send(VEC[i][57:34]);
      chk(vec_req(i), 32'(code_a), 32'(VEC[i][33:18]));
      chk(vec_req(i), 32'(code_b), 32'(VEC[i][17:2]));
      chk(vec_req(i), {30'b0, pd_a, pd_b}, 32'(VEC[i][1:0]));
    end

    // R7 upper bits taken for a 12-bit code
    chk("R7 narrow b", 32'(n_code_b), 32'h900);
    send(24'h30FEDF);
    chk("R7 wide a", 32'(code_a), 32'hFEDF);
    chk("R7 narrow a", 32'(n_code_a), 32'hFED);

    // R12 wake timer lengths
    idle(30);
    chk("R12 idle", 32'(busy), 32'h0);
    send(24'h4F0000);
    chk("R12 sleep no busy", 32'(busy), 32'h0);
    send(24'h100000);
    chk("R12 both first", 32'(busy), 32'h1);
    idle(BOTH - 1);
    chk("R12 both last", 32'(busy), 32'h1);
    idle(1);
    chk("R12 both end", 32'(busy), 32'h0);
    send(24'h110000);
    chk("R12 one first", 32'(busy), 32'h1);
    idle(ONE - 1);
    chk("R12 one last", 32'(busy), 32'h1);
    idle(1);
    chk("R12 one end", 32'(busy), 32'h0);

    // R8 strobe loads a pending word with bus idle
    send(24'h001111);
    chk("R8 before strobe", 32'(code_a), 32'hFEDF);
    ldac_n = 1'b0;
    idle(2);
    chk("R8 sync delay", 32'(code_a), 32'hFEDF);
    idle(1);
    chk("R8 loaded a", 32'(code_a), 32'h1111);
    chk("R8 loaded b", 32'(code_b), 32'h9001);
    ldac_n = 1'b1;
    idle(3);

    // R9 strobe during a transfer wakes without loading
    send(24'h400000);
    chk("R9 asleep", 32'(pd_a), 32'h1);
    send(24'h002222);
    xfer_active = 1'b1;
    ldac_n = 1'b0;
    idle(4);
    chk("R9 woken", 32'(pd_a), 32'h0);
    chk("R9 code held", 32'(code_a), 32'h1111);

    // R10 word completing under a low strobe
    send(24'h013333);
    chk("R10 exec then load b", 32'(code_b), 32'h3333);
    chk("R10 load a", 32'(code_a), 32'h2222);
    send(24'h4F0000);
    chk("R10 sleep suppressed", {30'b0, pd_a, pd_b}, 32'h0);
    xfer_active = 1'b0;
    ldac_n = 1'b1;
    idle(3);

    // R11 strobe held high: staged value stays out of the active code
    send(24'h004444);
    idle(10);
    chk("R11 held high", 32'(code_a), 32'h2222);

    finish_run();
  end
endmodule